// File: doc/BRIEF.md
# Rolling Row Readout Sequencer

This block sequences the readout of a pixel array one row at a time. The columns are grouped into a set of blocks that are all serviced in the same cycles. In each clock cycle of a row, the sequencer reads one pixel position in every block. In that same cycle it clears the position read one cycle earlier. After the last position, one more cycle clears it, so a row of P positions takes P+1 cycles. With the default geometry there are 8 blocks of 8 positions and 48 rows. A row therefore takes 9 cycles and a whole frame takes 432 cycles.

A frame begins when `start` is pulsed while the sequencer is idle. The outputs are a row address for the row decoder, a read index with a read strobe, and a clear index with a clear strobe. There are also per-block read and clear enables. In these enables, the two dead column positions at the outer edge of the first and the last block are masked off. After the final cycle of a frame, `frame_done` pulses for one cycle. With `auto_mode` high, the next frame starts in that same cycle. Otherwise the sequencer goes back to idle.

Each block's pixel data bus carries both counter values of the pixel being read. That bus and the pixel logic lie outside this block.

Top module: `rolling_readout_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it until a start, `busy`, `rd_en`, `rst_en`, `frame_done` and all per-block enables are low.
- R2: A `start` sampled high while idle makes the next cycle the first cycle of a frame: row 0, `rd_en` high, `rd_idx` 0. A `start` sampled while a frame is running has no effect on any output.
- R3: In row cycle k, with k from 0 to P-1, `rd_en` is high and `rd_idx` equals k.
- R4: In row cycle k, with k from 1 to P, `rst_en` is high and `rst_idx` equals k-1. In row cycle 0, `rst_en` is low.
- R5: In row cycle P, the clear-only cycle, `rd_en` is low so that the bus contents are marked invalid.
- R6: Each row lasts P+1 cycles. `row_sel` then advances by one, from 0 up to R-1.
- R7: A frame lasts exactly R*(P+1) cycles (432 by default). `frame_done` is high for exactly the one cycle after the frame's last cycle.
- R8: If `auto_mode` is high at the frame's last cycle, the cycle where `frame_done` is high is row 0, cycle 0 of a new frame. If it is low, the sequencer is idle in that cycle.
- R9: `blk_rd_en[b]` equals `rd_en` and `blk_rst_en[b]` equals `rst_en`, except in two cases. In block 0, positions 0 and 1 are forced low. In block NB-1, positions P-2 and P-1 are forced low.
- R10: `busy` is high exactly in the cycles that belong to a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame when idle |
| auto_mode | input | 1 | Run frames back to back when high |
| row_sel | output | 6 | Row address for the row decoder |
| rd_en | output | 1 | Read strobe, common to all blocks |
| rd_idx | output | 3 | Pixel position being read in every block |
| rst_en | output | 1 | Clear strobe, common to all blocks |
| rst_idx | output | 3 | Pixel position being cleared in every block |
| blk_rd_en | output | 8 | Per-block read enable with edge columns masked |
| blk_rst_en | output | 8 | Per-block clear enable with edge columns masked |
| busy | output | 1 | A frame is in progress |
| frame_done | output | 1 | One-cycle pulse after a frame completes |

## Verification
Two pairs of functions share cycles. Reading position k and clearing position k-1 happen together in every row cycle from 1 to P-1. In automatic mode, the `frame_done` pulse coincides with the first read of the next frame. The bench runs single frames and back-to-back automatic frames. It compares every cycle against a model that derives row and column from one flat position count, so overlapped strobes and the seam between frames are both checked. A stray `start` in the middle of a frame, and `auto_mode` dropping during a run, are judged by the frame boundaries that follow.

// File: rtl/rr_pkg.sv
package rr_pkg;

  // A column position is real unless it sits in the dead outer edge
  // of the first or the last block.
  function automatic logic col_live(int blk, int pos, int nblk, int ppb, int dead);
    col_live = !((blk == 0) && (pos < dead)) &&
               !((blk == nblk - 1) && (pos >= ppb - dead));
  endfunction

  // Cycles spent on one row: every position read, plus one clear-only cycle.
  function automatic int row_cycles(int ppb);
    row_cycles = ppb + 1;
  endfunction

endpackage

// File: rtl/rr_seq.sv
module rr_seq #(
  parameter int PPB   = 8,
  parameter int NR    = 48,
  parameter int CYC_W = 4,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             auto_mode,
  output logic             run,
  output logic [CYC_W-1:0] cyc,
  output logic [ROW_W-1:0] row,
  output logic             row_end,
  output logic             frame_end,
  output logic             frame_done
);
  localparam int LAST_CYC = rr_pkg::row_cycles(PPB) - 1;

  assign row_end   = run && (cyc == CYC_W'(LAST_CYC));
  assign frame_end = row_end && (row == ROW_W'(NR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      cyc        <= '0;
      row        <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= frame_end;
      if (run) begin
        if (row_end) begin
          cyc <= '0;
          if (frame_end) begin
            row <= '0;
            run <= auto_mode;
          end else begin
            row <= row + 1'b1;
          end
        end else begin
          cyc <= cyc + 1'b1;
        end
      end else if (start) begin
        run <= 1'b1;
        cyc <= '0;
        row <= '0;
      end
    end
  end
endmodule

// File: rtl/rr_strobe.sv
module rr_strobe #(
  parameter int PPB   = 8,
  parameter int CYC_W = 4,
  parameter int IDX_W = 3
) (
  input  logic             run,
  input  logic [CYC_W-1:0] cyc,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rst_en,
  output logic [IDX_W-1:0] rst_idx
);
  logic [CYC_W-1:0] prev_pos;

  assign prev_pos = cyc - 1'b1;
  assign rd_en    = run && (cyc < CYC_W'(PPB));
  assign rd_idx   = cyc[IDX_W-1:0];
  assign rst_en   = run && (cyc != '0);
  assign rst_idx  = prev_pos[IDX_W-1:0];
endmodule

// File: rtl/rr_blkmask.sv
module rr_blkmask #(
  parameter int NB    = 8,
  parameter int PPB   = 8,
  parameter int DEAD  = 2,
  parameter int IDX_W = 3
) (
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rst_en,
  input  logic [IDX_W-1:0] rst_idx,
  output logic [NB-1:0]    blk_rd_en,
  output logic [NB-1:0]    blk_rst_en
);
  for (genvar b = 0; b < NB; b++) begin : g_blk
    assign blk_rd_en[b]  = rd_en  && rr_pkg::col_live(b, int'(rd_idx),  NB, PPB, DEAD);
    assign blk_rst_en[b] = rst_en && rr_pkg::col_live(b, int'(rst_idx), NB, PPB, DEAD);
  end
endmodule

// File: rtl/rolling_readout_ctrl.sv
module rolling_readout_ctrl #(
  parameter int NB    = 8,
  parameter int PPB   = 8,
  parameter int NR    = 48,
  parameter int DEAD  = 2,
  localparam int IDX_W = $clog2(PPB),
  localparam int CYC_W = $clog2(PPB + 1),
  localparam int ROW_W = $clog2(NR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             auto_mode,
  output logic [ROW_W-1:0] row_sel,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rst_en,
  output logic [IDX_W-1:0] rst_idx,
  output logic [NB-1:0]    blk_rd_en,
  output logic [NB-1:0]    blk_rst_en,
  output logic             busy,
  output logic             frame_done
);
  logic             run;
  logic [CYC_W-1:0] cyc;
  logic             row_end;
  logic             frame_end;

  rr_seq #(.PPB(PPB), .NR(NR), .CYC_W(CYC_W), .ROW_W(ROW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .auto_mode(auto_mode),
    .run(run), .cyc(cyc), .row(row_sel), .row_end(row_end),
    .frame_end(frame_end), .frame_done(frame_done)
  );

  rr_strobe #(.PPB(PPB), .CYC_W(CYC_W), .IDX_W(IDX_W)) u_strobe (
    .run(run), .cyc(cyc), .rd_en(rd_en), .rd_idx(rd_idx),
    .rst_en(rst_en), .rst_idx(rst_idx)
  );

  rr_blkmask #(.NB(NB), .PPB(PPB), .DEAD(DEAD), .IDX_W(IDX_W)) u_mask (
    .rd_en(rd_en), .rd_idx(rd_idx), .rst_en(rst_en), .rst_idx(rst_idx),
    .blk_rd_en(blk_rd_en), .blk_rst_en(blk_rst_en)
  );

  assign busy = run;
endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
  parameter int NB    = 8,
  parameter int PPB   = 8,
  parameter int NR    = 48,
  parameter int DEAD  = 2,
  parameter int IDX_W = 3,
  parameter int ROW_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             auto_mode,
  input logic [ROW_W-1:0] row_sel,
  input logic             rd_en,
  input logic [IDX_W-1:0] rd_idx,
  input logic             rst_en,
  input logic [IDX_W-1:0] rst_idx,
  input logic [NB-1:0]    blk_rd_en,
  input logic [NB-1:0]    blk_rst_en,
  input logic             busy,
  input logic             frame_done,
  input logic             row_end,
  input logic             frame_end
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PPB - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NR - 1);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && rd_en && rd_idx == '0 && row_sel == '0));

  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx != LAST_IDX) |=> (rd_en && rd_idx == IDX_W'($past(rd_idx) + 1'b1)));

  p_clear_prev_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en) |=> (rst_en && rst_idx == $past(rd_idx)));

  p_clear_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == LAST_IDX) |=> (busy && !rd_en && row_end));

  p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (row_end && row_sel != LAST_ROW) |=> (rd_en && rd_idx == '0 &&
                                          row_sel == ROW_W'($past(row_sel) + 1'b1)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (frame_done && $rose(frame_done)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_auto_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && auto_mode) |=> (busy && rd_en && rd_idx == '0 && row_sel == '0));

  p_manual_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !auto_mode) |=> !busy);

  p_edge_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx < IDX_W'(DEAD)) |-> !blk_rd_en[0]);

  p_edge_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_idx >= IDX_W'(PPB - DEAD)) |-> !blk_rst_en[NB-1]);
endmodule

bind rolling_readout_ctrl rr_checker #(
  .NB(NB), .PPB(PPB), .NR(NR), .DEAD(DEAD), .IDX_W(IDX_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .auto_mode(auto_mode),
  .row_sel(row_sel), .rd_en(rd_en), .rd_idx(rd_idx), .rst_en(rst_en),
  .rst_idx(rst_idx), .blk_rd_en(blk_rd_en), .blk_rst_en(blk_rst_en),
  .busy(busy), .frame_done(frame_done), .row_end(row_end), .frame_end(frame_end)
);

// File: tb/rolling_readout_ctrl_tb.sv
`timescale 1ns/1ps
module rolling_readout_ctrl_tb;
  localparam int NB = 8, PPB = 8, NR = 48, DEAD = 2;
  localparam int FRAME = NR * (PPB + 1);

  typedef struct {
    string ctx;
    int    busy, done, row, rd, ridx, clr, cidx, bmask_rd, bmask_clr;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, auto_mode = 1'b0;
  logic [5:0] row_sel;
  logic       rd_en, rst_en, busy, frame_done;
  logic [2:0] rd_idx, rst_idx;
  logic [7:0] blk_rd_en, blk_rst_en;

  int vectors = 0, fails = 0;
  bit finished = 0;
  exp_t q[$];

  // model state: one flat position in the frame
  int m_run = 0, m_pos = 0, m_done = 0;

  always #5 clk = ~clk;

  rolling_readout_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .auto_mode(auto_mode),
    .row_sel(row_sel), .rd_en(rd_en), .rd_idx(rd_idx), .rst_en(rst_en),
    .rst_idx(rst_idx), .blk_rd_en(blk_rd_en), .blk_rst_en(blk_rst_en),
    .busy(busy), .frame_done(frame_done)
  );

  function automatic int live(int b, int p);
    if (b == 0 && p < DEAD) return 0;
    if (b == NB - 1 && p > PPB - 1 - DEAD) return 0;
    return 1;
  endfunction

  // Advance the model over the coming edge and queue what it predicts.
  task automatic step(input bit s, input bit a, input bit r, input string ctx);
    exp_t e;
    int c, nd;
    @(negedge clk);
    start = s; auto_mode = a; rst_n = r;
    if (!r) begin
      m_run = 0; m_pos = 0; m_done = 0;
    end else begin
      nd = 0;
      if (m_run != 0) begin
        if (m_pos == FRAME - 1) begin
          m_pos = 0; nd = 1; m_run = a;
        end else m_pos++;
      end else if (s) begin
        m_run = 1; m_pos = 0;
      end
      m_done = nd;
    end
    c = m_pos % (PPB + 1);
    e.ctx = ctx;
    e.busy = m_run;
    e.done = m_done;
    e.row = m_pos / (PPB + 1);
    e.rd = (m_run != 0 && c < PPB) ? 1 : 0;
    e.ridx = c;
    e.clr = (m_run != 0 && c > 0) ? 1 : 0;
    e.cidx = c - 1;
    e.bmask_rd = 0; e.bmask_clr = 0;
    for (int b = 0; b < NB; b++) begin
      if (e.rd != 0 && live(b, e.ridx) != 0) e.bmask_rd |= (1 << b);
      if (e.clr != 0 && live(b, e.cidx) != 0) e.bmask_clr |= (1 << b);
    end
    q.push_back(e);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops one prediction per edge and compares after outputs settle.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({e.ctx, " R10 busy"}, int'(busy), e.busy);
        check({e.ctx, " R7 frame_done"}, int'(frame_done), e.done);
        check({e.ctx, " R5 rd_en"}, int'(rd_en), e.rd);
        check({e.ctx, " R4 rst_en"}, int'(rst_en), e.clr);
        check({e.ctx, " R9 blk_rd_en"}, int'(blk_rd_en), e.bmask_rd);
        check({e.ctx, " R9 blk_rst_en"}, int'(blk_rst_en), e.bmask_clr);
        if (e.busy != 0) check({e.ctx, " R6 row_sel"}, int'(row_sel), e.row);
        if (e.rd != 0)   check({e.ctx, " R3 rd_idx"}, int'(rd_idx), e.ridx);
        if (e.clr != 0)  check({e.ctx, " R4 rst_idx"}, int'(rst_idx), e.cidx);
      end
    end
  end

  initial begin
    #1ms;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset and quiet idle
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R1");
    for (int i = 0; i < 3; i++) step(0, 0, 1, "R1");
    // R2: start a single manual frame; stray start mid-frame ignored
    step(1, 0, 1, "R2");
    for (int i = 0; i < 100; i++) step(0, 0, 1, "R3");
    step(1, 0, 1, "R2");
    step(1, 0, 1, "R2");
    for (int i = 0; i < FRAME; i++) step(0, 0, 1, "R7");
    // R8: manual mode leaves the sequencer idle
    for (int i = 0; i < 5; i++) step(0, 0, 1, "R8");
    // R8: automatic back-to-back frames, then drop auto mid third frame
    step(1, 1, 1, "R2");
    for (int i = 0; i < 2 * FRAME + 50; i++) step(0, 1, 1, "R8");
    for (int i = 0; i < FRAME; i++) step(0, 0, 1, "R8");
    for (int i = 0; i < 5; i++) step(0, 0, 1, "R10");
    repeat (3) @(posedge clk);
    #3;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule